// File: doc/BRIEF.md
# Line-Organized Reorder Buffer

This block is the in-order retirement stage of an out-of-order core. The decoder hands it a group of up to three operations per cycle. The whole group is placed in one line of a fixed grid of 24 lines, so up to 72 operations can be in flight. Integer and floating-point operations share this single structure. Execution units report completion through tagged write-back ports in any order. An operation stalled on a cache miss simply stays in its slot while younger, independent operations keep completing around it.

Lines retire strictly in program order, one whole line per cycle, once every occupied slot of the oldest line has finished. If a finished slot in the oldest line carries an exception or a branch misprediction, the block retires the older slots of that line and reports the faulting slot on a recovery port. It then discards everything younger and rewinds allocation to the faulting line. An external flush input empties the buffer in one cycle.

Top module: `line_reorder_buffer`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_line` is 0, and `ret_valid` and `rec_valid` are 0.
- R2: A group offered with `alloc_valid` high, a nonzero `alloc_mask` and `alloc_ready` high takes the line shown on `alloc_line`. Successive groups take successive lines, and line LINES-1 is followed by line 0. A group whose mask is zero is ignored and takes no line.
- R3: Once LINES lines are occupied (LINES*SLOTS operations), `alloc_ready` is 0. It returns to 1 in the cycle after a line retires.
- R4: Completions may arrive in any order. A line retires only when all of its occupied slots are done. While the oldest line has an unfinished slot, no line retires, even if every younger line is done.
- R5: Lines retire in allocation order, one per cycle, in the cycle after their last completion is written. `ret_line` is the line index and `ret_mask` bit i marks an occupied slot i. Slot i's destination tag is at `ret_dest[i*TAG_W +: TAG_W]` and its result is at `ret_data[i*DATA_W +: DATA_W]`.
- R6: A completion addressed to a slot that was left empty by a partial group is ignored. It does not appear in `ret_mask` and its fault flags have no effect.
- R7: A fault is the lowest-numbered occupied slot of the oldest line that is done with `wb_exc` or `wb_mispred` set, with all lower occupied slots done. It raises `rec_valid` with `rec_line` and `rec_slot`. `rec_mispred` is 1 for a misprediction and 0 for an exception, and an exception wins if both are set. In the same cycle the lower slots retire, with `ret_valid` set only if there are any. In the next cycle the buffer is empty and `alloc_line` equals the faulting line.
- R8: A faulting completion in the oldest line has no effect while a lower-numbered occupied slot of that line is not yet done.
- R9: In a cycle with `flush_req` high, `ret_valid`, `rec_valid` and `alloc_ready` are 0. In the next cycle the buffer is empty and `alloc_line` equals the line that was oldest.
- R10: All WB write-back ports are accepted in the same cycle, each writing its own slot.
- R11: `alloc_ready` is 0 in a recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Decoder offers a group |
| alloc_mask | input | 3 | Occupied slots of the offered group |
| alloc_dest | input | 21 | Destination tag per slot, slot i at bits i*7 |
| alloc_ready | output | 1 | Group can be accepted this cycle |
| alloc_line | output | 5 | Line the next group will take |
| wb_valid | input | 2 | Completion valid per write-back port |
| wb_line | input | 10 | Line tag per port, 5 bits each |
| wb_slot | input | 4 | Slot tag per port, 2 bits each |
| wb_exc | input | 2 | Completed operation raised an exception |
| wb_mispred | input | 2 | Completed branch was mispredicted |
| wb_data | input | 32 | Result per port, 16 bits each |
| flush_req | input | 1 | Discard all buffered operations |
| ret_valid | output | 1 | Slots are retiring this cycle |
| ret_line | output | 5 | Index of the retiring line |
| ret_mask | output | 3 | Retiring slots |
| ret_dest | output | 21 | Destination tags of retiring slots |
| ret_data | output | 48 | Results of retiring slots |
| rec_valid | output | 1 | Fault found in the oldest line, recovery this cycle |
| rec_line | output | 5 | Line of the faulting operation |
| rec_slot | output | 2 | Slot of the faulting operation |
| rec_mispred | output | 1 | 1 for misprediction, 0 for exception |

## Verification
A lost done bit leaves the oldest line stuck, so `ret_valid` never rises after the last completion. A stale occupied bit shows up as a wrong `ret_mask` or a phantom fault when that line reaches the head. In both cases the symptom appears one cycle after the line's final completion is written. A pointer that wraps or rewinds wrongly shows on `alloc_line` at the very next group, and again as an out-of-order `ret_line` once the affected lines retire. The sweeps cover every nonzero group mask, every fault slot under both fault kinds, and a full fill with completions in reverse order.

// File: rtl/lrb_pkg.sv
// Package: shared types and helpers for the line reorder buffer.
// Assumes ring indices are smaller than the ring size.
package lrb_pkg;

    // Per-slot bookkeeping flags
    typedef struct packed {
        logic vld;
        logic done;
        logic exc;
        logic mis;
    } slot_state_t;

    // Next index on a ring of the given size
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned size);
        return (idx + 1 >= size) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/lrb_entry_array.sv
// Entry array: one flag set, destination tag and result per slot of every line.
// Allocation writes a whole line; completions set done and fault flags on
// occupied, unfinished slots only; free and clear drop occupancy.
// Assumes allocation never targets a line being freed in the same cycle.
module lrb_entry_array
    import lrb_pkg::*;
#(
    parameter int LINES  = 24,
    parameter int SLOTS  = 3,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    parameter int WB     = 2,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_we,
    input  logic [LINE_W-1:0]       alloc_line,
    input  logic [SLOTS-1:0]        alloc_mask,
    input  logic [SLOTS*TAG_W-1:0]  alloc_dest,
    input  logic [WB-1:0]           wb_valid,
    input  logic [WB*LINE_W-1:0]    wb_line,
    input  logic [WB*SLOT_W-1:0]    wb_slot,
    input  logic [WB-1:0]           wb_exc,
    input  logic [WB-1:0]           wb_mis,
    input  logic [WB*DATA_W-1:0]    wb_data,
    input  logic                    free_we,
    input  logic [LINE_W-1:0]       free_line,
    input  logic                    clear_all,
    input  logic [LINE_W-1:0]       rd_line,
    output logic [SLOTS-1:0]        rd_vld,
    output logic [SLOTS-1:0]        rd_done,
    output logic [SLOTS-1:0]        rd_exc,
    output logic [SLOTS-1:0]        rd_mis,
    output logic [SLOTS*TAG_W-1:0]  rd_dest,
    output logic [SLOTS*DATA_W-1:0] rd_data
);

    localparam int ENTRIES = LINES * SLOTS;

    logic [ENTRIES-1:0]        vld_bus;
    logic [ENTRIES-1:0]        done_bus;
    logic [ENTRIES-1:0]        exc_bus;
    logic [ENTRIES-1:0]        mis_bus;
    logic [ENTRIES*TAG_W-1:0]  dest_bus;
    logic [ENTRIES*DATA_W-1:0] data_bus;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam int IDX = l * SLOTS + s;

            slot_state_t       st_q;
            logic [TAG_W-1:0]  dest_q;
            logic [DATA_W-1:0] data_q;
            logic              hit;
            logic              hit_exc;
            logic              hit_mis;
            logic [DATA_W-1:0] hit_data;
            logic              own_alloc;
            logic              own_free;
            logic              take_wb;

            // Select the lowest-numbered write-back port addressing this slot
            always_comb begin
                hit      = 1'b0;
                hit_exc  = 1'b0;
                hit_mis  = 1'b0;
                hit_data = '0;
                for (int p = WB - 1; p >= 0; p--) begin
                    if (wb_valid[p] &&
                        wb_line[p*LINE_W +: LINE_W] == LINE_W'(l) &&
                        wb_slot[p*SLOT_W +: SLOT_W] == SLOT_W'(s)) begin
                        hit      = 1'b1;
                        hit_exc  = wb_exc[p];
                        hit_mis  = wb_mis[p];
                        hit_data = wb_data[p*DATA_W +: DATA_W];
                    end
                end
            end

            assign own_alloc = alloc_we && (alloc_line == LINE_W'(l));
            assign own_free  = free_we && (free_line == LINE_W'(l));
            assign take_wb   = hit && st_q.vld && !st_q.done;

            // Slot flags: clear, allocate or record completion
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else if (clear_all || own_free) begin
                    st_q.vld <= 1'b0;
                end else if (own_alloc) begin
                    st_q <= '{vld: alloc_mask[s], done: 1'b0, exc: 1'b0, mis: 1'b0};
                end else if (take_wb) begin
                    st_q.done <= 1'b1;
                    st_q.exc  <= hit_exc;
                    st_q.mis  <= hit_mis;
                end
            end

            // Slot payload: destination at allocation, result at completion
            always_ff @(posedge clk) begin
                if (own_alloc) begin
                    dest_q <= alloc_dest[s*TAG_W +: TAG_W];
                end
                if (take_wb && !own_alloc) begin
                    data_q <= hit_data;
                end
            end

            assign vld_bus[IDX]                  = st_q.vld;
            assign done_bus[IDX]                 = st_q.done;
            assign exc_bus[IDX]                  = st_q.exc;
            assign mis_bus[IDX]                  = st_q.mis;
            assign dest_bus[IDX*TAG_W +: TAG_W]  = dest_q;
            assign data_bus[IDX*DATA_W +: DATA_W] = data_q;
        end
    end

    // Read port: gather the slots of the requested line
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            rd_vld[s]  = vld_bus[int'(rd_line) * SLOTS + s];
            rd_done[s] = done_bus[int'(rd_line) * SLOTS + s];
            rd_exc[s]  = exc_bus[int'(rd_line) * SLOTS + s];
            rd_mis[s]  = mis_bus[int'(rd_line) * SLOTS + s];
            rd_dest[s*TAG_W +: TAG_W]   = dest_bus[(int'(rd_line) * SLOTS + s) * TAG_W +: TAG_W];
            rd_data[s*DATA_W +: DATA_W] = data_bus[(int'(rd_line) * SLOTS + s) * DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/lrb_head_scan.sv
// Head scan: walks the slots of the oldest line in slot order and decides
// whether the line is complete, still waiting, or holds the first fault.
// Purely combinational; assumes the caller qualifies with line occupancy.
module lrb_head_scan #(
    parameter int SLOTS = 3,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0]  vld,
    input  logic [SLOTS-1:0]  done,
    input  logic [SLOTS-1:0]  exc,
    input  logic [SLOTS-1:0]  mis,
    output logic [SLOTS-1:0]  keep_mask,
    output logic              stall,
    output logic              fault,
    output logic [SLOT_W-1:0] fault_slot,
    output logic              fault_mis
);

    logic blocked;

    // Stop at the first unfinished or faulting slot; earlier clean slots retire
    always_comb begin
        blocked    = 1'b0;
        stall      = 1'b0;
        fault      = 1'b0;
        fault_slot = '0;
        fault_mis  = 1'b0;
        keep_mask  = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (vld[s] && !blocked) begin
                if (!done[s]) begin
                    stall   = 1'b1;
                    blocked = 1'b1;
                end else if (exc[s] || mis[s]) begin
                    fault      = 1'b1;
                    fault_slot = SLOT_W'(s);
                    fault_mis  = mis[s] && !exc[s];
                    blocked    = 1'b1;
                end else begin
                    keep_mask[s] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lrb_ring_ptr.sv
// Ring pointers: head (oldest line) and tail (next free line) over LINES
// lines, with an occupancy count. Rewind pulls the tail back to the head.
// Assumes push is never raised when full nor pop when empty.
module lrb_ring_ptr
    import lrb_pkg::*;
#(
    parameter int LINES = 24,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              rewind,
    output logic [LINE_W-1:0] head,
    output logic [LINE_W-1:0] tail,
    output logic              full,
    output logic              empty
);

    logic [CNT_W-1:0] count_q;

    // Advance, rewind or reset the pointers and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            count_q <= '0;
        end else if (rewind) begin
            tail    <= head;
            count_q <= '0;
        end else begin
            if (push) tail <= LINE_W'(ring_next(int'(tail), LINES));
            if (pop)  head <= LINE_W'(ring_next(int'(head), LINES));
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign full  = (count_q == CNT_W'(LINES));
    assign empty = (count_q == '0);

endmodule

// File: rtl/line_reorder_buffer.sv
// Line reorder buffer: allocates decoder groups into whole lines, records
// out-of-order completions, retires the oldest line in order and recovers
// from a fault in the oldest line by discarding all younger work.
// Assumes write-back tags name slots that were allocated and not retired.
module line_reorder_buffer #(
    parameter int LINES  = 24,
    parameter int SLOTS  = 3,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    parameter int WB     = 2,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic [SLOTS-1:0]        alloc_mask,
    input  logic [SLOTS*TAG_W-1:0]  alloc_dest,
    output logic                    alloc_ready,
    output logic [LINE_W-1:0]       alloc_line,
    input  logic [WB-1:0]           wb_valid,
    input  logic [WB*LINE_W-1:0]    wb_line,
    input  logic [WB*SLOT_W-1:0]    wb_slot,
    input  logic [WB-1:0]           wb_exc,
    input  logic [WB-1:0]           wb_mispred,
    input  logic [WB*DATA_W-1:0]    wb_data,
    input  logic                    flush_req,
    output logic                    ret_valid,
    output logic [LINE_W-1:0]       ret_line,
    output logic [SLOTS-1:0]        ret_mask,
    output logic [SLOTS*TAG_W-1:0]  ret_dest,
    output logic [SLOTS*DATA_W-1:0] ret_data,
    output logic                    rec_valid,
    output logic [LINE_W-1:0]       rec_line,
    output logic [SLOT_W-1:0]       rec_slot,
    output logic                    rec_mispred
);

    logic [LINE_W-1:0]       head;
    logic [LINE_W-1:0]       tail;
    logic                    full;
    logic                    empty;
    logic [SLOTS-1:0]        hd_vld;
    logic [SLOTS-1:0]        hd_done;
    logic [SLOTS-1:0]        hd_exc;
    logic [SLOTS-1:0]        hd_mis;
    logic [SLOTS*TAG_W-1:0]  hd_dest;
    logic [SLOTS*DATA_W-1:0] hd_data;
    logic [SLOTS-1:0]        keep_mask;
    logic                    hd_stall;
    logic                    hd_fault;
    logic [SLOT_W-1:0]       hd_fault_slot;
    logic                    hd_fault_mis;
    logic                    line_retire;
    logic                    rec_fire;
    logic                    alloc_fire;
    logic                    drop_all;

    // Decide this cycle's retirement, recovery and allocation
    always_comb begin
        line_retire = !empty && !flush_req && !hd_stall && !hd_fault;
        rec_fire    = !empty && !flush_req && hd_fault;
        alloc_ready = !full && !rec_fire && !flush_req;
        alloc_fire  = alloc_valid && alloc_ready && (|alloc_mask);
        drop_all    = flush_req || rec_fire;
    end

    lrb_ring_ptr #(.LINES(LINES)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (alloc_fire),
        .pop    (line_retire),
        .rewind (drop_all),
        .head   (head),
        .tail   (tail),
        .full   (full),
        .empty  (empty)
    );

    lrb_entry_array #(
        .LINES  (LINES),
        .SLOTS  (SLOTS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .WB     (WB)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_we   (alloc_fire),
        .alloc_line (tail),
        .alloc_mask (alloc_mask),
        .alloc_dest (alloc_dest),
        .wb_valid   (wb_valid),
        .wb_line    (wb_line),
        .wb_slot    (wb_slot),
        .wb_exc     (wb_exc),
        .wb_mis     (wb_mispred),
        .wb_data    (wb_data),
        .free_we    (line_retire),
        .free_line  (head),
        .clear_all  (drop_all),
        .rd_line    (head),
        .rd_vld     (hd_vld),
        .rd_done    (hd_done),
        .rd_exc     (hd_exc),
        .rd_mis     (hd_mis),
        .rd_dest    (hd_dest),
        .rd_data    (hd_data)
    );

    lrb_head_scan #(.SLOTS(SLOTS)) u_scan (
        .vld        (hd_vld),
        .done       (hd_done),
        .exc        (hd_exc),
        .mis        (hd_mis),
        .keep_mask  (keep_mask),
        .stall      (hd_stall),
        .fault      (hd_fault),
        .fault_slot (hd_fault_slot),
        .fault_mis  (hd_fault_mis)
    );

    // Drive the retirement and recovery ports
    always_comb begin
        ret_valid   = (line_retire || rec_fire) && (|keep_mask);
        ret_line    = head;
        ret_mask    = ret_valid ? keep_mask : '0;
        ret_dest    = hd_dest;
        ret_data    = hd_data;
        rec_valid   = rec_fire;
        rec_line    = head;
        rec_slot    = rec_fire ? hd_fault_slot : '0;
        rec_mispred = rec_fire && hd_fault_mis;
        alloc_line  = tail;
    end

endmodule

// File: rtl/lrb_checker.sv
// Checker: tracks line occupancy from the ports alone and checks the
// allocation, retirement, recovery and flush rules over time.
module lrb_checker
    import lrb_pkg::*;
#(
    parameter int LINES = 24,
    parameter int SLOTS = 3,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic [SLOTS-1:0]  alloc_mask,
    input logic              alloc_ready,
    input logic [LINE_W-1:0] alloc_line,
    input logic              ret_valid,
    input logic [SLOTS-1:0]  ret_mask,
    input logic              rec_valid,
    input logic              flush_req
);

    logic [CNT_W-1:0] occ_q;
    logic             take;

    assign take = alloc_valid && alloc_ready && (|alloc_mask);

    // Count occupied lines as seen at the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (flush_req || rec_valid) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CNT_W'(take) - CNT_W'(ret_valid);
        end
    end

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CNT_W'(LINES));

    assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CNT_W'(LINES)) |-> !alloc_ready);

    assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> (!ret_valid && !rec_valid));

    assert_mask_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (|ret_mask));

    assert_alloc_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (alloc_line == LINE_W'(ring_next(int'($past(alloc_line)), LINES))));

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (!ret_valid && !rec_valid && !alloc_ready));

    assert_rec_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> (!ret_valid && !rec_valid));

    assert_rec_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !alloc_ready);

endmodule

bind line_reorder_buffer lrb_checker #(.LINES(LINES), .SLOTS(SLOTS)) u_lrb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_mask  (alloc_mask),
    .alloc_ready (alloc_ready),
    .alloc_line  (alloc_line),
    .ret_valid   (ret_valid),
    .ret_mask    (ret_mask),
    .rec_valid   (rec_valid),
    .flush_req   (flush_req)
);

// File: tb/line_reorder_buffer_bench.sv
// Bench: sweeps fill/drain, every group mask, every fault slot and kind,
// and flush, with expected values computed from line and slot numbers.
module line_reorder_buffer_bench;

    localparam int LINES  = 24;
    localparam int SLOTS  = 3;
    localparam int TAG_W  = 7;
    localparam int DATA_W = 16;
    localparam int WB     = 2;
    localparam int LINE_W = 5;
    localparam int SLOT_W = 2;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    alloc_valid;
    logic [SLOTS-1:0]        alloc_mask;
    logic [SLOTS*TAG_W-1:0]  alloc_dest;
    logic                    alloc_ready;
    logic [LINE_W-1:0]       alloc_line;
    logic [WB-1:0]           wb_valid;
    logic [WB*LINE_W-1:0]    wb_line;
    logic [WB*SLOT_W-1:0]    wb_slot;
    logic [WB-1:0]           wb_exc;
    logic [WB-1:0]           wb_mispred;
    logic [WB*DATA_W-1:0]    wb_data;
    logic                    flush_req;
    logic                    ret_valid;
    logic [LINE_W-1:0]       ret_line;
    logic [SLOTS-1:0]        ret_mask;
    logic [SLOTS*TAG_W-1:0]  ret_dest;
    logic [SLOTS*DATA_W-1:0] ret_data;
    logic                    rec_valid;
    logic [LINE_W-1:0]       rec_line;
    logic [SLOT_W-1:0]       rec_slot;
    logic                    rec_mispred;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    line_reorder_buffer u_line_reorder_buffer (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_mask(alloc_mask), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_line(alloc_line),
        .wb_valid(wb_valid), .wb_line(wb_line), .wb_slot(wb_slot),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred), .wb_data(wb_data),
        .flush_req(flush_req),
        .ret_valid(ret_valid), .ret_line(ret_line), .ret_mask(ret_mask),
        .ret_dest(ret_dest), .ret_data(ret_data),
        .rec_valid(rec_valid), .rec_line(rec_line), .rec_slot(rec_slot),
        .rec_mispred(rec_mispred)
    );

    function automatic logic [TAG_W-1:0] dst(input int l, input int s);
        return TAG_W'(l * 3 + s);
    endfunction

    function automatic logic [DATA_W-1:0] dat(input int l, input int s);
        return DATA_W'(l * 97 + s * 13 + 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        alloc_valid = 1'b0; alloc_mask = '0; alloc_dest = '0;
        wb_valid = '0; wb_line = '0; wb_slot = '0; wb_exc = '0; wb_mispred = '0; wb_data = '0;
        flush_req = 1'b0;
    endtask

    task automatic alloc_put(input int mask, input int l);
        alloc_valid = 1'b1;
        alloc_mask  = SLOTS'(mask);
        for (int s = 0; s < SLOTS; s++) alloc_dest[s*TAG_W +: TAG_W] = dst(l, s);
    endtask

    task automatic wb_put(input int p, input int l, input int s, input logic e, input logic m,
                          input logic [DATA_W-1:0] d);
        wb_valid[p] = 1'b1;
        wb_line[p*LINE_W +: LINE_W] = LINE_W'(l);
        wb_slot[p*SLOT_W +: SLOT_W] = SLOT_W'(s);
        wb_exc[p] = e;
        wb_mispred[p] = m;
        wb_data[p*DATA_W +: DATA_W] = d;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected end of run");
        finish_run();
    end

    initial begin
        int tl;
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 ready", alloc_ready, 1);
        chk("R1 alloc_line", alloc_line, 0);
        chk("R1 ret_valid", ret_valid, 0);
        chk("R1 rec_valid", rec_valid, 0);

        // Fill all lines with full groups
        for (int i = 0; i < LINES; i++) begin
            @(negedge clk); clear_in(); alloc_put(7, i); #1;
            chk("R2 alloc_line on fill", alloc_line, i);
            chk("R3 ready while room", alloc_ready, 1);
        end
        @(negedge clk); clear_in(); alloc_put(7, 99); #1;
        chk("R3 full blocks", alloc_ready, 0);

        // Complete youngest first, leaving one slot of the oldest line pending
        for (int l = LINES - 1; l >= 0; l--) begin
            for (int s = SLOTS - 1; s >= 0; s--) begin
                if (!(l == 0 && s == 1)) begin
                    @(negedge clk); clear_in(); wb_put(0, l, s, 1'b0, 1'b0, dat(l, s)); #1;
                    chk("R4 head blocks retirement", ret_valid, 0);
                end
            end
        end
        chk("R3 still full", alloc_ready, 0);
        @(negedge clk); clear_in(); wb_put(0, 0, 1, 1'b0, 1'b0, dat(0, 1)); #1;
        chk("R4 pending slot", ret_valid, 0);
        for (int i = 0; i < LINES; i++) begin
            @(negedge clk); clear_in(); #1;
            chk("R5 ret_valid", ret_valid, 1);
            chk("R5 ret_line order", ret_line, i);
            chk("R5 ret_mask", ret_mask, 7);
            for (int s = 0; s < SLOTS; s++) begin
                chk("R5 ret_dest", ret_dest[s*TAG_W +: TAG_W], dst(i, s));
                chk("R5 ret_data", ret_data[s*DATA_W +: DATA_W], dat(i, s));
            end
            if (i == 0) chk("R3 full until retire", alloc_ready, 0);
            if (i == 1) chk("R3 ready after retire", alloc_ready, 1);
        end
        @(negedge clk); clear_in(); #1;
        chk("R5 drained", ret_valid, 0);
        chk("R2 wrap to line 0", alloc_line, 0);

        // Every group mask: zero mask ignored, partial masks keep holes empty
        @(negedge clk); clear_in(); alloc_put(0, 50); #1;
        chk("R2 empty group", alloc_line, 0);
        for (int m = 1; m < 8; m++) begin
            @(negedge clk); clear_in(); alloc_put(m, m - 1); #1;
            chk("R2 alloc_line after partial", alloc_line, m - 1);
        end
        for (int j = 6; j >= 0; j--) begin
            int msk;
            int hole;
            msk = j + 1;
            hole = -1;
            for (int s = 0; s < SLOTS; s++) if (!msk[s] && hole < 0) hole = s;
            for (int s = SLOTS - 1; s >= 0; s--) begin
                if (msk[s]) begin
                    @(negedge clk); clear_in(); wb_put(0, j, s, 1'b0, 1'b0, dat(j, s));
                    if (hole >= 0) wb_put(1, j, hole, 1'b1, 1'b1, 16'hdead);
                    #1;
                    chk("R4 wait for line 0", ret_valid, 0);
                end
            end
        end
        for (int j = 0; j < 7; j++) begin
            @(negedge clk); clear_in(); #1;
            chk("R6 ret_valid", ret_valid, 1);
            chk("R6 ret_line", ret_line, j);
            chk("R6 mask matches group", ret_mask, j + 1);
            chk("R6 hole fault ignored", rec_valid, 0);
        end
        @(negedge clk); clear_in(); #1;
        chk("R5 drained after sweep", ret_valid, 0);
        tl = 7;

        // Every fault slot and kind in the oldest line
        for (int k = 0; k < 2; k++) begin
            for (int f = 0; f < SLOTS; f++) begin
                int a;
                int b;
                logic e;
                logic mm;
                a = tl;
                b = (tl + 1) % LINES;
                e  = (k == 0);
                mm = (k == 1) || (f == 2);
                @(negedge clk); clear_in(); alloc_put(7, a); #1;
                chk("R2 alloc faulting line", alloc_line, a);
                @(negedge clk); clear_in(); alloc_put(7, b); #1;
                chk("R2 alloc younger line", alloc_line, b);
                for (int s = 0; s < SLOTS; s++) begin
                    @(negedge clk); clear_in(); wb_put(0, b, s, 1'b0, 1'b0, dat(b, s)); #1;
                    chk("R4 younger done waits", ret_valid, 0);
                end
                @(negedge clk); clear_in(); wb_put(0, a, f, e, mm, dat(a, f)); #1;
                chk("R8 no fault yet", rec_valid, 0);
                for (int s = 0; s < f; s++) begin
                    @(negedge clk); clear_in(); wb_put(0, a, s, 1'b0, 1'b0, dat(a, s)); #1;
                    chk("R8 fault waits for older slot", rec_valid, 0);
                    chk("R8 no retire while waiting", ret_valid, 0);
                end
                @(negedge clk); clear_in(); #1;
                chk("R7 rec_valid", rec_valid, 1);
                chk("R7 rec_line", rec_line, a);
                chk("R7 rec_slot", rec_slot, f);
                chk("R7 rec_mispred", rec_mispred, k);
                chk("R7 older slots retire", ret_valid, (f > 0) ? 1 : 0);
                if (f > 0) begin
                    chk("R7 ret_mask older", ret_mask, (1 << f) - 1);
                    chk("R7 ret_line", ret_line, a);
                end
                chk("R11 no alloc in recovery", alloc_ready, 0);
                @(negedge clk); clear_in(); #1;
                chk("R7 younger flushed", ret_valid, 0);
                chk("R7 no repeat", rec_valid, 0);
                chk("R7 tail at faulting line", alloc_line, a);
                chk("R7 ready after recovery", alloc_ready, 1);
            end
        end

        // Flush with the head line ready to retire
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); clear_in(); alloc_put(7, tl + i); #1;
            chk("R2 alloc before flush", alloc_line, tl + i);
        end
        for (int l = tl + 2; l >= tl; l--) begin
            @(negedge clk); clear_in();
            wb_put(0, l, 2, 1'b0, 1'b0, dat(l, 2));
            wb_put(1, l, 1, 1'b0, 1'b0, dat(l, 1)); #1;
            chk("R10 waiting", ret_valid, 0);
            @(negedge clk); clear_in(); wb_put(0, l, 0, 1'b0, 1'b0, dat(l, 0)); #1;
            chk("R10 waiting", ret_valid, 0);
        end
        @(negedge clk); clear_in(); flush_req = 1'b1; #1;
        chk("R9 no retire on flush", ret_valid, 0);
        chk("R9 no recovery on flush", rec_valid, 0);
        chk("R9 no alloc on flush", alloc_ready, 0);
        @(negedge clk); clear_in(); #1;
        chk("R9 empty after flush", ret_valid, 0);
        chk("R9 tail at old head", alloc_line, tl);
        @(negedge clk); clear_in(); alloc_put(5, tl + 40); #1;
        chk("R9 realloc line", alloc_line, tl);
        @(negedge clk); clear_in(); #1;
        chk("R9 fresh line not done", ret_valid, 0);
        @(negedge clk); clear_in();
        wb_put(0, tl, 0, 1'b0, 1'b0, dat(tl + 40, 0));
        wb_put(1, tl, 2, 1'b0, 1'b0, dat(tl + 40, 2)); #1;
        chk("R10 before retire", ret_valid, 0);
        @(negedge clk); clear_in(); #1;
        chk("R10 both ports retire", ret_valid, 1);
        chk("R10 ret_mask", ret_mask, 5);
        chk("R10 ret_line", ret_line, tl);
        chk("R10 port0 data", ret_data[0 +: DATA_W], dat(tl + 40, 0));
        chk("R10 port1 data", ret_data[2*DATA_W +: DATA_W], dat(tl + 40, 2));
        chk("R10 dest slot2", ret_dest[2*TAG_W +: TAG_W], dst(tl + 40, 2));
        @(negedge clk); clear_in(); #1;
        chk("R5 idle at end", ret_valid, 0);

        finish_run();
    end

endmodule